// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Wakeup

This block receives asynchronous serial frames and supports a multi-drop protocol. In multiprocessor mode every frame carries one extra bit after the eight data bits. That bit marks the frame as a station-ID frame (1) or a payload frame (0). A station that is not being addressed sets the wakeup-enable bit. The receiver then drops payload frames completely: no data moves to the receive data register, no flag is set and no error is looked for. It stays in that state until an ID frame arrives. That ID frame is received as normal, the wakeup-enable bit clears itself, and every later frame is delivered until software arms the filter again.

The receiver oversamples the line 16 times per bit. Its sample tick comes from one of two sources. The first is an internal divider, which can also put a bit-rate clock out on a pin. The second is an external clock that runs at sixteen times the bit rate. Software sees a received-data register, sticky flags for data-full, framing error and overrun, and the last received multiprocessor bit. It clears each flag with a one-cycle pulse. A receive interrupt and an error interrupt are derived from the flags and a common enable.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, rdata_o is 0, and rdrf_o, fer_o, orer_o, mpb_o, wake_en_o, rxi_o, eri_o and sck_oe_o are all 0.
- R2: A frame is a low start bit, then 8 data bits with the least significant bit first. In multiprocessor mode (mp_mode_i=1) one multiprocessor bit follows, and then a high stop bit. Each bit is sampled once at mid-bit. An accepted frame loads its data into rdata_o and sets rdrf_o.
- R3: With mp_mode_i=0 the frame has no multiprocessor bit. wake_en_o then has no effect: frames are delivered and wake_en_o stays 1.
- R4: While mp_mode_i=1 and wake_en_o=1, a frame whose multiprocessor bit is 0 leaves rdata_o unchanged, does not set rdrf_o, and leaves wake_en_o at 1.
- R5: Such a dropped frame sets neither fer_o (even with a low stop bit) nor orer_o (even while rdrf_o is 1).
- R6: While mp_mode_i=1 and wake_en_o=1, a frame whose multiprocessor bit is 1 clears wake_en_o, sets mpb_o to 1, and is received as a normal frame. Frames that follow are delivered.
- R7: In multiprocessor mode with the filter off, mpb_o takes the multiprocessor bit of every accepted frame.
- R8: An accepted frame whose stop bit samples low sets fer_o. A fer_clr_i pulse clears it.
- R9: An accepted frame that completes while rdrf_o=1 sets orer_o and leaves rdata_o unchanged.
- R10: An rdrf_clr_i pulse clears rdrf_o. If a frame is accepted in the same cycle, the set wins.
- R11: rxi_o = rie_i AND rdrf_o. eri_o = rie_i AND (fer_o OR orer_o).
- R12: clk_sel_i=00 uses an internal tick once every div_i+1 clock cycles and drives no clock out (sck_oe_o=0). clk_sel_i=01 uses the same tick and drives sck_o at the bit rate, one period per 16 ticks, with sck_oe_o=1. clk_sel_i=1x takes one tick per rising edge of ext_clk_i and ignores the internal divider.
- R13: A low pulse on rx_i that has ended before the middle of the start bit is not taken as a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| ext_clk_i | input | 1 | External sample clock, 16x bit rate |
| clk_sel_i | input | 2 | Tick source: 00 internal, 01 internal with clock out, 1x external |
| div_i | input | DIV_W | Internal divider: one tick every div_i+1 cycles |
| mp_mode_i | input | 1 | Multiprocessor frame format enable |
| wake_set_i | input | 1 | Pulse: arm the wakeup filter |
| rdrf_clr_i | input | 1 | Pulse: clear data-full flag |
| fer_clr_i | input | 1 | Pulse: clear framing-error flag |
| orer_clr_i | input | 1 | Pulse: clear overrun flag |
| rie_i | input | 1 | Receive and error interrupt enable |
| rdata_o | output | 8 | Received data register |
| rdrf_o | output | 1 | Receive data full |
| fer_o | output | 1 | Framing error |
| orer_o | output | 1 | Overrun error |
| mpb_o | output | 1 | Last received multiprocessor bit |
| wake_en_o | output | 1 | Wakeup filter armed |
| rxi_o | output | 1 | Receive interrupt |
| eri_o | output | 1 | Error interrupt |
| sck_o | output | 1 | Bit-rate clock output |
| sck_oe_o | output | 1 | Output enable for sck_o |

## Verification
The filter is exercised with payload frames that carry each kind of trouble it must hide: a changed data byte, a low stop bit, and arrival while data-full is set. This separates real suppression from a filter that only gates the data load. An ID frame after these shows that the self-clear happens and that the frame after it is delivered. The same stimulus is repeated with multiprocessor mode off, which shows that the filter is tied to that mode. Tick sources are compared with frames timed at 16, 32 and 64 cycles per bit. A frame sent with the external clock stopped must be lost, and a start glitch must give no frame.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int OVS_W  = $clog2(OVS);
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [1:0] CKS_INT_OUT = 2'b01;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_MPB,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              stop_ok;
    } frame_t;

endpackage

// File: rtl/mprx_tick_gen.sv
module mprx_tick_gen
    import mprx_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int EXT_SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ext_clk_i,
    output logic             tick_o,
    output logic             sck_o,
    output logic             sck_oe_o
);

    typedef struct packed {
        logic [DIV_W-1:0]  div_cnt;
        logic [EXT_SYNC:0] ext_sh;
        logic [OVS_W-1:0]  sck_cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;
    logic     int_tick;
    logic     ext_edge;

    always_comb begin
        // newest sample in bit 0; bit EXT_SYNC holds the previous synchronized value
        ext_edge = s_q.ext_sh[EXT_SYNC-1] & ~s_q.ext_sh[EXT_SYNC];
        int_tick = (s_q.div_cnt >= div_i);
        tick_o   = clk_sel_i[1] ? ext_edge : int_tick;

        s_d         = s_q;
        s_d.ext_sh  = {s_q.ext_sh[EXT_SYNC-1:0], ext_clk_i};
        s_d.div_cnt = int_tick ? '0 : s_q.div_cnt + 1'b1;
        if (int_tick) begin
            s_d.sck_cnt = s_q.sck_cnt + 1'b1;
        end

        sck_oe_o = (clk_sel_i == CKS_INT_OUT);
        sck_o    = sck_oe_o & s_q.sck_cnt[OVS_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // internal ticks are never back to back once the divider is above zero
    assert_int_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_sel_i[1] && div_i != '0 && tick_o) |=> (!tick_o || clk_sel_i[1] || div_i == '0));

endmodule

// File: rtl/mprx_frame_rx.sv
module mprx_frame_rx
    import mprx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   rx_i,
    input  logic   mp_mode_i,
    output logic   frame_v_o,
    output frame_t frame_o
);

    localparam logic [OVS_W-1:0] HALF_CNT = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] LAST_CNT = OVS_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] rx_sh;
        rx_state_e              st;
        logic [OVS_W-1:0]       cnt;
        logic [BIT_W-1:0]       bitn;
        logic [DATA_W-1:0]      shreg;
        logic                   mpb;
        logic                   frame_v;
        frame_t                 frame;
    } rx_st_t;

    rx_st_t s_d, s_q;
    logic   rx_s;

    assign rx_s = s_q.rx_sh[SYNC_STAGES-1];

    always_comb begin
        s_d         = s_q;
        s_d.frame_v = 1'b0;
        s_d.rx_sh   = {s_q.rx_sh[SYNC_STAGES-2:0], rx_i};
        if (tick_i) begin
            case (s_q.st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.cnt == HALF_CNT) begin
                        s_d.cnt  = '0;
                        s_d.bitn = '0;
                        s_d.mpb  = 1'b0;
                        s_d.st   = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt   = '0;
                        s_d.shreg = {rx_s, s_q.shreg[DATA_W-1:1]};
                        if (s_q.bitn == LAST_BIT) begin
                            s_d.st = mp_mode_i ? RX_MPB : RX_STOP;
                        end else begin
                            s_d.bitn = s_q.bitn + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_MPB: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt = '0;
                        s_d.mpb = rx_s;
                        s_d.st  = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt           = '0;
                        s_d.st            = RX_IDLE;
                        s_d.frame_v       = 1'b1;
                        s_d.frame.data    = s_q.shreg;
                        s_d.frame.mpb     = s_q.mpb;
                        s_d.frame.stop_ok = rx_s;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.rx_sh <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_v_o = s_q.frame_v;
    assign frame_o   = s_q.frame;

    // a completed frame is a single-cycle event
    assert_frame_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_v_o |=> !frame_v_o);

endmodule

// File: rtl/mprx_flags.sv
module mprx_flags
    import mprx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_v_i,
    input  frame_t            frame_i,
    input  logic              mp_mode_i,
    input  logic              wake_set_i,
    input  logic              rdrf_clr_i,
    input  logic              fer_clr_i,
    input  logic              orer_clr_i,
    input  logic              rie_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdrf_o,
    output logic              fer_o,
    output logic              orer_o,
    output logic              mpb_o,
    output logic              wake_en_o,
    output logic              rxi_o,
    output logic              eri_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rdrf;
        logic              fer;
        logic              orer;
        logic              mpb;
        logic              wake;
    } flag_st_t;

    flag_st_t s_d, s_q;
    logic     filt;
    logic     take;

    always_comb begin
        filt = mp_mode_i & s_q.wake;
        take = frame_v_i & ~(filt & ~frame_i.mpb);

        s_d = s_q;
        if (wake_set_i) s_d.wake = 1'b1;
        if (rdrf_clr_i) s_d.rdrf = 1'b0;
        if (fer_clr_i)  s_d.fer  = 1'b0;
        if (orer_clr_i) s_d.orer = 1'b0;

        if (take) begin
            if (mp_mode_i)        s_d.mpb  = frame_i.mpb;
            if (filt)             s_d.wake = 1'b0;
            if (!frame_i.stop_ok) s_d.fer  = 1'b1;
            if (s_q.rdrf) begin
                s_d.orer = 1'b1;
            end else begin
                s_d.rdata = frame_i.data;
                s_d.rdrf  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o   = s_q.rdata;
    assign rdrf_o    = s_q.rdrf;
    assign fer_o     = s_q.fer;
    assign orer_o    = s_q.orer;
    assign mpb_o     = s_q.mpb;
    assign wake_en_o = s_q.wake;
    assign rxi_o     = rie_i & s_q.rdrf;
    assign eri_o     = rie_i & (s_q.fer | s_q.orer);

    assert_nonmp_keeps_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v_i && !mp_mode_i && wake_en_o) |=> wake_en_o);

    assert_dropped_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v_i && mp_mode_i && wake_en_o && !frame_i.mpb && !rdrf_o) |=> (!rdrf_o && $stable(rdata_o)));

    assert_dropped_no_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v_i && mp_mode_i && wake_en_o && !frame_i.mpb && !fer_o && !orer_o) |=> (!fer_o && !orer_o));

    assert_id_frame_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v_i && mp_mode_i && wake_en_o && frame_i.mpb) |=> (!wake_en_o && mpb_o && rdrf_o));

    assert_overrun_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v_i && !(mp_mode_i && wake_en_o && !frame_i.mpb) && rdrf_o) |=> (orer_o && $stable(rdata_o)));

    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v_i && !(mp_mode_i && wake_en_o && !frame_i.mpb) && !rdrf_o) |=> rdrf_o);

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mprx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              ext_clk_i,
    input  logic [1:0]        clk_sel_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              mp_mode_i,
    input  logic              wake_set_i,
    input  logic              rdrf_clr_i,
    input  logic              fer_clr_i,
    input  logic              orer_clr_i,
    input  logic              rie_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdrf_o,
    output logic              fer_o,
    output logic              orer_o,
    output logic              mpb_o,
    output logic              wake_en_o,
    output logic              rxi_o,
    output logic              eri_o,
    output logic              sck_o,
    output logic              sck_oe_o
);

    logic   tick;
    logic   frame_v;
    frame_t frame;

    mprx_tick_gen #(
        .DIV_W    (DIV_W),
        .EXT_SYNC (SYNC_STAGES)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel_i (clk_sel_i),
        .div_i     (div_i),
        .ext_clk_i (ext_clk_i),
        .tick_o    (tick),
        .sck_o     (sck_o),
        .sck_oe_o  (sck_oe_o)
    );

    mprx_frame_rx #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .rx_i      (rx_i),
        .mp_mode_i (mp_mode_i),
        .frame_v_o (frame_v),
        .frame_o   (frame)
    );

    mprx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_v_i  (frame_v),
        .frame_i    (frame),
        .mp_mode_i  (mp_mode_i),
        .wake_set_i (wake_set_i),
        .rdrf_clr_i (rdrf_clr_i),
        .fer_clr_i  (fer_clr_i),
        .orer_clr_i (orer_clr_i),
        .rie_i      (rie_i),
        .rdata_o    (rdata_o),
        .rdrf_o     (rdrf_o),
        .fer_o      (fer_o),
        .orer_o     (orer_o),
        .mpb_o      (mpb_o),
        .wake_en_o  (wake_en_o),
        .rxi_o      (rxi_o),
        .eri_o      (eri_o)
    );

endmodule

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       ext_clk = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic [7:0] div = 8'd0;
    logic       mp_mode = 1'b1;
    logic       wake_set = 1'b0;
    logic       rdrf_clr = 1'b0;
    logic       fer_clr = 1'b0;
    logic       orer_clr = 1'b0;
    logic       rie = 1'b1;
    logic [7:0] rdata;
    logic       rdrf, fer, orer, mpb, wake_en, rxi, eri, sck, sck_oe;

    logic       ext_run = 1'b0;
    int         ext_cnt = 0;
    int         vectors = 0;
    int         miscompares = 0;

    mp_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .ext_clk_i(ext_clk),
        .clk_sel_i(clk_sel), .div_i(div), .mp_mode_i(mp_mode),
        .wake_set_i(wake_set), .rdrf_clr_i(rdrf_clr), .fer_clr_i(fer_clr),
        .orer_clr_i(orer_clr), .rie_i(rie), .rdata_o(rdata), .rdrf_o(rdrf),
        .fer_o(fer), .orer_o(orer), .mpb_o(mpb), .wake_en_o(wake_en),
        .rxi_o(rxi), .eri_o(eri), .sck_o(sck), .sck_oe_o(sck_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // external 16x clock: one period every 4 system cycles
    always @(negedge clk) begin
        if (ext_run) begin
            ext_cnt = ext_cnt + 1;
            if (ext_cnt == 2) begin
                ext_cnt = 0;
                ext_clk = ~ext_clk;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic mp, input logic with_mp,
                              input logic stop_hi, input int bitcyc);
        @(negedge clk);
        hold(1'b0, bitcyc);
        for (int i = 0; i < 8; i++) hold(d[i], bitcyc);
        if (with_mp) hold(mp, bitcyc);
        if (stop_hi) hold(1'b1, bitcyc);
        else hold(1'b0, (bitcyc * 3) / 4);
        hold(1'b1, 2 * bitcyc);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: rdrf_clr = 1'b1;
            1: fer_clr = 1'b1;
            2: orer_clr = 1'b1;
            default: wake_set = 1'b1;
        endcase
        @(negedge clk);
        rdrf_clr = 1'b0; fer_clr = 1'b0; orer_clr = 1'b0; wake_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "rdata", rdata, 0);
        chk("R1", "rdrf", rdrf, 0);
        chk("R1", "fer/orer", {fer, orer}, 0);
        chk("R1", "mpb/wake", {mpb, wake_en}, 0);
        chk("R1", "rxi/eri", {rxi, eri}, 0);
        chk("R1", "sck_oe", sck_oe, 0);
    endtask

    task automatic t_basic;
        send_frame(8'hA5, 1'b0, 1'b1, 1'b1, 16);
        chk("R2", "rdata", rdata, 8'hA5);
        chk("R2", "rdrf", rdrf, 1);
        chk("R11", "rxi", rxi, 1);
        chk("R7", "mpb zero", mpb, 0);
        pulse(0);
        chk("R10", "rdrf cleared", rdrf, 0);
        chk("R11", "rxi off", rxi, 0);
    endtask

    task automatic t_mpb_follow;
        send_frame(8'h3C, 1'b1, 1'b1, 1'b1, 16);
        chk("R7", "mpb one", mpb, 1);
        chk("R2", "rdata 3C", rdata, 8'h3C);
        pulse(0);
        send_frame(8'h11, 1'b0, 1'b1, 1'b1, 16);
        chk("R7", "mpb back to zero", mpb, 0);
        chk("R2", "rdata 11", rdata, 8'h11);
        pulse(0);
    endtask

    task automatic t_filter;
        send_frame(8'h22, 1'b0, 1'b1, 1'b1, 16);
        chk("R2", "rdata 22", rdata, 8'h22);
        pulse(3);
        chk("R4", "wake armed", wake_en, 1);
        send_frame(8'h77, 1'b0, 1'b1, 1'b1, 16);
        chk("R4", "rdata kept", rdata, 8'h22);
        chk("R5", "no overrun on dropped frame", orer, 0);
        chk("R4", "wake still armed", wake_en, 1);
        send_frame(8'h55, 1'b0, 1'b1, 1'b0, 16);
        chk("R5", "no framing error on dropped frame", fer, 0);
        pulse(0);
        send_frame(8'h66, 1'b0, 1'b1, 1'b1, 16);
        chk("R4", "rdrf not set", rdrf, 0);
        chk("R4", "rdata still kept", rdata, 8'h22);
    endtask

    task automatic t_wakeup;
        send_frame(8'h9A, 1'b1, 1'b1, 1'b1, 16);
        chk("R6", "wake cleared", wake_en, 0);
        chk("R6", "mpb set", mpb, 1);
        chk("R6", "id frame data", rdata, 8'h9A);
        chk("R6", "id frame rdrf", rdrf, 1);
        pulse(0);
        send_frame(8'h44, 1'b0, 1'b1, 1'b1, 16);
        chk("R6", "delivery resumed", rdata, 8'h44);
        chk("R6", "resumed rdrf", rdrf, 1);
        pulse(0);
    endtask

    task automatic t_fer;
        send_frame(8'h0F, 1'b0, 1'b1, 1'b0, 16);
        chk("R8", "fer set", fer, 1);
        chk("R11", "eri", eri, 1);
        pulse(1);
        chk("R8", "fer cleared", fer, 0);
        pulse(0);
        rie = 1'b0;
        send_frame(8'h0E, 1'b0, 1'b1, 1'b0, 16);
        chk("R8", "fer set again", fer, 1);
        chk("R11", "eri masked", eri, 0);
        chk("R11", "rxi masked", rxi, 0);
        rie = 1'b1;
        pulse(1);
        pulse(0);
    endtask

    task automatic t_orer;
        send_frame(8'h12, 1'b0, 1'b1, 1'b1, 16);
        send_frame(8'h34, 1'b0, 1'b1, 1'b1, 16);
        chk("R9", "orer set", orer, 1);
        chk("R9", "rdata kept", rdata, 8'h12);
        chk("R11", "eri on overrun", eri, 1);
        pulse(2);
        pulse(0);
        chk("R9", "orer cleared", orer, 0);
    endtask

    task automatic t_nonmp;
        mp_mode = 1'b0;
        pulse(3);
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 16);
        chk("R3", "delivered", rdata, 8'hC3);
        chk("R3", "rdrf", rdrf, 1);
        chk("R3", "wake unaffected", wake_en, 1);
        pulse(0);
    endtask

    task automatic t_glitch;
        @(negedge clk);
        hold(1'b0, 4);
        hold(1'b1, 64);
        chk("R13", "no frame from glitch", rdrf, 0);
        chk("R13", "rdata", rdata, 8'hC3);
    endtask

    task automatic t_clocks;
        int edges;
        logic prev;
        div = 8'd1;
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1, 32);
        chk("R12", "divider 1 rdata", rdata, 8'h5A);
        pulse(0);
        div = 8'd0;
        clk_sel = 2'b10;
        send_frame(8'hBD, 1'b0, 1'b0, 1'b1, 64);
        chk("R12", "stopped ext clock gives no frame", rdrf, 0);
        ext_run = 1'b1;
        send_frame(8'hE7, 1'b0, 1'b0, 1'b1, 64);
        chk("R12", "ext clock rdata", rdata, 8'hE7);
        chk("R12", "sck_oe ext", sck_oe, 0);
        ext_run = 1'b0;
        pulse(0);
        clk_sel = 2'b01;
        @(negedge clk);
        chk("R12", "sck_oe internal out", sck_oe, 1);
        edges = 0;
        prev = sck;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (sck && !prev) edges++;
            prev = sck;
        end
        chk("R12", "sck rising edges in 160 ticks", edges, 10);
        clk_sel = 2'b00;
        @(negedge clk);
        chk("R12", "sck_oe internal", sck_oe, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_basic;
        t_mpb_follow;
        t_filter;
        t_wakeup;
        t_fer;
        t_orer;
        t_nonmp;
        t_glitch;
        t_clocks;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule